// File: doc/BRIEF.md
# Keyed-Disable Watchdog Timer

This block is a watchdog down-counter that sits on a simple single-cycle register bus. Software chooses a period, starts the timer, and services it from then on by writing to the count register. Each service write reloads the count from the period. If software fails to service the timer in time, the count reaches zero. The block then sets a sticky expiry flag and raises a one-cycle request on one of three outputs: a reset request, a non-maskable interrupt request or a general-purpose interrupt request. A fourth setting raises no request at all, but the counter and the flag still work as normal.

The timer runs whenever the 8-bit key field of the control register holds any value other than 0xAD. Only the exact key 0xAD stops it, so a stray write is unlikely to disable the watchdog. The count register is read-only in effect: any write to it acts as a reload. The same reload loads a stopped timer without starting it. The expiry flag stays set until software writes a 1 to it.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the control register reads 0x0000_00AD, so the timer is stopped with event select 00 and the flag clear. The period and count registers read 0, and all three request outputs are low.
- R2: The control key field is bits [7:0]. Writing 0xAD there stops the count at its value, and writing any other value lets it run. A new key takes effect from the clock edge after the write commits.
- R3: Any write to the count register (word index 2) copies the period into the count on that edge. A stopped timer then holds the loaded value, and a running timer counts down from it again, which services the watchdog.
- R4: While running, the count drops by one per clock. When it reaches zero it stays there until a reload.
- R5: The event select is bits [9:8]. The value 00 maps to `rstReq`, 01 to `nmiReq` and 10 to `irqReq`. The selected output is high for exactly one cycle, on the edge where a running count steps from 1 to 0, and at most one request is high at any time.
- R6: With event select 11 the count still runs down and the flag still sets, but no request output ever goes high.
- R7: The expiry flag is bit 15 of the control register. It sets when the count expires and then stays set. Writing 1 to bit 15 clears it, and writing 0 leaves it as it is. If a clear and an expiry fall on the same edge, the flag ends up set.
- R8: Control bits [14:10] and [31:16] always read as zero, and writes to them have no effect.
- R9: Word index 0 selects the control register and index 1 selects the period register, which is fully readable and writable. Index 2 selects the count, and index 3 reads as zero.
- R10: A count that is already zero, whether it was reloaded with a period of 0 or was idle when the timer started, raises no request and does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access strobe for this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Word index of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from address |
| rstReq | output | 1 | Reset request pulse |
| nmiReq | output | 1 | Non-maskable interrupt request pulse |
| irqReq | output | 1 | General-purpose interrupt request pulse |

## Verification
The assertions assume that the bus sees at most one access per cycle, and that a write always presents all 32 data bits at once. They also assume reset is held across at least one clock edge. The bench drives every access in its own cycle, changing inputs only at the falling edge and releasing the strobe before the next access. It always starts a timed run by stopping the timer and clearing the flag, so that each expiry window starts from a known count.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Event routing encoding held in control bits [9:8]
  typedef enum logic [1:0] {
    EV_RESET = 2'b00,
    EV_NMI   = 2'b01,
    EV_IRQ   = 2'b10,
    EV_NONE  = 2'b11
  } evtSel_e;

  // Strobes from control to count datapath
  typedef struct packed {
    logic loadCount;
    logic runCount;
  } cntStrobe_t;

  localparam int unsigned REG_CTRL   = 0;
  localparam int unsigned REG_PERIOD = 1;
  localparam int unsigned REG_COUNT  = 2;

  localparam int unsigned KEY_LSB  = 0;
  localparam int unsigned KEY_W    = 8;
  localparam int unsigned EVT_LSB  = 8;
  localparam int unsigned FLAG_BIT = 15;
  localparam int unsigned NUM_EVT  = 3;

endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             expireHit
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign expireHit = strobe.runCount && !strobe.loadCount && (count == ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.loadCount) begin
      count <= period;
    end else if (strobe.runCount && (count != '0)) begin
      count <= count - ONE;
    end
  end

  // R2
  hold_stopped_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.runCount && !strobe.loadCount) |=> $stable(count));

  // R3
  reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCount |=> (count == $past(period)));

  // R4
  decrement_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.runCount && !strobe.loadCount && count != '0) |=> (count == $past(count) - ONE));

  // R4
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadCount && count == '0) |=> (count == '0));

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned ADDR_W      = 2,
  parameter logic [7:0]  DISABLE_KEY = 8'hAD
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              expireHit,
  output cntStrobe_t        strobe,
  output logic [CNT_W-1:0]  period,
  output logic [NUM_EVT-1:0] evtVec
);

  localparam int unsigned DATA_W = 32;

  logic [KEY_W-1:0] keyReg;
  evtSel_e          evtReg;
  logic             flagReg;
  logic             wrCtrl;
  logic             wrPeriod;
  logic             wrCount;
  logic [DATA_W-1:0] ctrlView;

  assign wrCtrl   = busSel && busWrite && (busAddr == ADDR_W'(REG_CTRL));
  assign wrPeriod = busSel && busWrite && (busAddr == ADDR_W'(REG_PERIOD));
  assign wrCount  = busSel && busWrite && (busAddr == ADDR_W'(REG_COUNT));

  assign strobe.loadCount = wrCount;
  assign strobe.runCount  = (keyReg != DISABLE_KEY);

  always_comb begin
    ctrlView = '0;
    ctrlView[KEY_LSB +: KEY_W] = keyReg;
    ctrlView[EVT_LSB +: 2]     = evtReg;
    ctrlView[FLAG_BIT]         = flagReg;
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_W'(REG_CTRL)) begin
      busRdata = ctrlView;
    end else if (busAddr == ADDR_W'(REG_PERIOD)) begin
      busRdata = DATA_W'(period);
    end else if (busAddr == ADDR_W'(REG_COUNT)) begin
      busRdata = DATA_W'(count);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyReg <= DISABLE_KEY;
      evtReg <= EV_RESET;
      period <= '0;
    end else begin
      if (wrCtrl) begin
        keyReg <= busWdata[KEY_LSB +: KEY_W];
        evtReg <= evtSel_e'(busWdata[EVT_LSB +: 2]);
      end
      if (wrPeriod) begin
        period <= busWdata[CNT_W-1:0];
      end
    end
  end

  // Set has priority over a write-one clear on the same edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagReg <= 1'b0;
    end else if (expireHit) begin
      flagReg <= 1'b1;
    end else if (wrCtrl && busWdata[FLAG_BIT]) begin
      flagReg <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    always_ff @(posedge clk) begin
      if (!rstN) begin
        evtVec[i] <= 1'b0;
      end else begin
        evtVec[i] <= expireHit && (evtReg == evtSel_e'(i));
      end
    end
  end

  // R5
  evt_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(evtVec));

  // R5
  evt_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtVec != '0) |=> (evtVec == '0));

  // R6
  evt_none_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtVec != '0) |-> ($past(evtReg) != EV_NONE));

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagReg && !(wrCtrl && busWdata[FLAG_BIT])) |=> flagReg);

  // R7
  evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtVec != '0) |-> flagReg);

  // R8
  ctrl_unused_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(REG_CTRL)) |-> (busRdata[31:16] == '0 && busRdata[14:10] == '0));

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned ADDR_W      = 2,
  parameter logic [7:0]  DISABLE_KEY = 8'hAD
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              rstReq,
  output logic              nmiReq,
  output logic              irqReq
);

  cntStrobe_t         strobe;
  logic [CNT_W-1:0]   period;
  logic [CNT_W-1:0]   count;
  logic               expireHit;
  logic [NUM_EVT-1:0] evtVec;

  wdt_ctrl #(
    .CNT_W(CNT_W),
    .ADDR_W(ADDR_W),
    .DISABLE_KEY(DISABLE_KEY)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .busSel(busSel),
    .busWrite(busWrite),
    .busAddr(busAddr),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .count(count),
    .expireHit(expireHit),
    .strobe(strobe),
    .period(period),
    .evtVec(evtVec)
  );

  wdt_datapath #(
    .CNT_W(CNT_W)
  ) u_datapath (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .period(period),
    .count(count),
    .expireHit(expireHit)
  );

  assign rstReq = evtVec[EV_RESET];
  assign nmiReq = evtVec[EV_NMI];
  assign irqReq = evtVec[EV_IRQ];

endmodule

// File: tb/wdt_keyed_bench.sv
module wdt_keyed_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [31:0] busWdata = 32'd0;
  logic [31:0] busRdata;
  logic        rstReq;
  logic        nmiReq;
  logic        irqReq;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  wdt_keyed u_wdt_keyed (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .rstReq(rstReq), .nmiReq(nmiReq), .irqReq(irqReq)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge; commits on the next rising edge, returns at the falling edge after it
  task automatic wr(logic [1:0] a, logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  function automatic logic [31:0] evts();
    return {29'd0, irqReq, nmiReq, rstReq};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd0, v); chk("R1", "ctrl", v, 32'h0000_00AD);
    rd(2'd1, v); chk("R1", "period", v, 32'd0);
    rd(2'd2, v); chk("R1", "count", v, 32'd0);
    chk("R1", "requests", evts(), 32'd0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    wr(2'd1, 32'h1234_5678);
    rd(2'd1, v); chk("R9", "period readback", v, 32'h1234_5678);
    rd(2'd3, v); chk("R9", "index 3", v, 32'd0);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); chk("R8", "ctrl all ones", v, 32'h0000_03FF);
    wr(2'd0, 32'h0000_7CAD);
    rd(2'd0, v); chk("R8", "ctrl unused bits", v, 32'h0000_00AD);
  endtask

  task automatic t_key();
    logic [31:0] v;
    wr(2'd1, 32'd7);
    wr(2'd2, 32'd0);
    rd(2'd2, v); chk("R3", "load while stopped", v, 32'd7);
    repeat (10) @(negedge clk);
    rd(2'd2, v); chk("R2", "stopped holds", v, 32'd7);
    wr(2'd0, 32'h0000_0000);
    rd(2'd2, v); chk("R2", "first edge after key", v, 32'd7);
    @(negedge clk);
    rd(2'd2, v); chk("R4", "one step", v, 32'd6);
    wr(2'd0, 32'h0000_00AD);
    rd(2'd2, v); chk("R2", "stop edge", v, 32'd5);
    repeat (5) @(negedge clk);
    rd(2'd2, v); chk("R2", "stopped again", v, 32'd5);
  endtask

  // Stop and clear, load period p, start with the given select
  task automatic arm(logic [1:0] sel, int p);
    wr(2'd0, 32'h0000_80AD | (32'(sel) << 8));
    wr(2'd1, 32'(p));
    wr(2'd2, 32'd0);
    wr(2'd0, 32'(sel) << 8);
  endtask

  task automatic t_expire(logic [1:0] sel, int p);
    logic [31:0] v;
    logic [31:0] hitVec;
    string rq;
    hitVec = (sel == 2'b11) ? 32'd0 : (32'd1 << sel);
    rq = (sel == 2'b11) ? "R6" : "R5";
    arm(sel, p);
    for (int i = 1; i <= p; i++) begin
      @(negedge clk);
      rd(2'd2, v); chk("R4", "countdown", v, 32'(p - i));
      chk(rq, "requests", evts(), (i == p) ? hitVec : 32'd0);
    end
    rd(2'd0, v); chk("R7", "flag set on expiry", {31'd0, v[15]}, 32'd1);
    @(negedge clk);
    chk(rq, "pulse ends", evts(), 32'd0);
    repeat (3) @(negedge clk);
    rd(2'd2, v); chk("R4", "hold at zero", v, 32'd0);
    chk(rq, "no repeat", evts(), 32'd0);
  endtask

  task automatic t_service();
    logic [31:0] v;
    arm(2'b00, 6);
    repeat (4) @(negedge clk);
    rd(2'd2, v); chk("R4", "before service", v, 32'd2);
    wr(2'd2, 32'd0);
    rd(2'd2, v); chk("R3", "service reload", v, 32'd6);
    repeat (5) @(negedge clk);
    rd(2'd0, v); chk("R7", "flag clear before expiry", {31'd0, v[15]}, 32'd0);
    chk("R3", "no early request", evts(), 32'd0);
    @(negedge clk);
    chk("R5", "expiry after service", evts(), 32'd1);
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    wr(2'd0, 32'h0000_0000);
    rd(2'd0, v); chk("R7", "write 0 keeps flag", {31'd0, v[15]}, 32'd1);
    wr(2'd0, 32'h0000_8000);
    rd(2'd0, v); chk("R7", "write 1 clears flag", {31'd0, v[15]}, 32'd0);
    arm(2'b00, 2);
    @(negedge clk);
    wr(2'd0, 32'h0000_8000);
    rd(2'd0, v); chk("R7", "set wins over clear", {31'd0, v[15]}, 32'd1);
    chk("R5", "request on collision edge", evts(), 32'd1);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    arm(2'b00, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R10", "no request at zero", evts(), 32'd0);
    end
    rd(2'd0, v); chk("R10", "flag stays clear", {31'd0, v[15]}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_key();
    t_expire(2'b00, 4);
    t_expire(2'b01, 3);
    t_expire(2'b10, 5);
    t_expire(2'b11, 4);
    t_service();
    t_sticky();
    t_zero();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule